// File: doc/BRIEF.md
# Crosspoint Command Controller

This block is the control unit of one column crosspoint in a linear array of processing elements. The elements share `K_SEG` parallel bus segments. A merged input queue delivers one command at a time to the block. Each command carries an opcode, the source address of the connection and its destination address. The block works out which way the command travels: toward the left neighbour, toward the right neighbour, or to the local processor. For connection acknowledgements and teardowns it also claims or releases a segment in its configuration table. It then emits the resulting command or commands on registered per-port outputs.

Connection setup is circuit-switched. A request travels to the destination and claims nothing on the way. A segment is claimed only when the acceptance travels back. If no segment is free at this column, the block splits the acceptance into two commands: a teardown sent toward the destination, which frees the segments already claimed further along, and a rejection sent toward the source. The table is exported so that the data switch fabric can steer its segments.

Top module: `xp_ctrl`

## Requirements
- R1: Routing depends on an address compared with `MY_IDX`. A lower address leaves on output port 1 (left), a higher one on port 2 (right), and an equal one on port 0 (local). Commands that travel toward the destination use the destination address. Commands that travel toward the source use the source address.
- R2: The opcodes are 1 request, 2 accept, 3 reject, 4 teardown and 5 teardown-done. A request is forwarded toward the destination, and the table does not change.
- R3: On an accept with no entry for the same pair, the block claims the highest-numbered free segment, records the pair and the route, and forwards the accept toward the source. The route is held in `seg_route[4i+3:4i+2]` (the port toward the source) and `seg_route[4i+1:4i]` (the port toward the destination).
- R4: On an accept for a source/destination pair that already holds a segment, the block claims no second segment and forwards the accept.
- R5: On an accept when every segment is in use, the block emits a teardown toward the destination and a reject toward the source in the same cycle, and the table does not change.
- R6: Reject and teardown-done are forwarded toward the source, and the table does not change.
- R7: A teardown releases the segment that holds its exact pair, if there is one, and is always forwarded toward the destination.
- R8: After a command is accepted, `cmd_ready` is low for the next cycle. The results appear two clock edges after acceptance, as a single-cycle pulse, and no cycle carries more than two outputs.
- R9: After reset every segment is free, no output is valid and `cmd_ready` is high.
- R10: Opcodes 0, 6 and 7 produce no output and leave the table unchanged.
- R11: A pair with source and destination swapped is a separate connection and holds its own segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Queue head holds a command |
| cmd_ready | output | 1 | Block takes the queue head this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_src | input | AW | Connection source address |
| cmd_dst | input | AW | Connection destination address |
| out_vld | output | 3 | Per-port output valid (0 local, 1 left, 2 right) |
| out_op | output | 9 | Per-port opcode, 3 bits per port |
| out_src | output | 3*AW | Per-port source address |
| out_dst | output | 3*AW | Per-port destination address |
| seg_used | output | K_SEG | Segment occupied flags |
| seg_route | output | 4*K_SEG | Per-segment port toward source and toward destination |

## Verification
Properties checked on every cycle:
- `cmd_ready` drops after each accepted command, and every output pulse comes two edges after an acceptance.
- A segment is claimed only in a cycle that carries an accept, and never more than one at a time.
- A segment is released only in a cycle that carries a teardown.
- A paired teardown and reject appear only when the table is full.

Some properties need ordered sequences and a reference table in the bench:
- which segment the highest-free choice picks;
- that a repeated pair is reused and a swapped pair is not;
- that a teardown frees exactly the matching entry;
- the exact port each opcode leaves on.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam logic [2:0] OP_REQ     = 3'd1;
  localparam logic [2:0] OP_ACCEPT  = 3'd2;
  localparam logic [2:0] OP_REJECT  = 3'd3;
  localparam logic [2:0] OP_TEAR    = 3'd4;
  localparam logic [2:0] OP_TEARDN  = 3'd5;

  localparam logic [1:0] PORT_LOC   = 2'd0;
  localparam logic [1:0] PORT_LEFT  = 2'd1;
  localparam logic [1:0] PORT_RIGHT = 2'd2;
  localparam int         N_PORTS    = 3;
endpackage

// File: rtl/xp_route.sv
module xp_route #(
  parameter int AW     = 3,
  parameter int MY_IDX = 3
) (
  input  logic [AW-1:0] addr,
  output logic [1:0]    port
);
  import xp_pkg::*;
  localparam logic [AW-1:0] SELF = AW'(MY_IDX);

  always_comb begin
    if (addr < SELF)      port = PORT_LEFT;
    else if (addr > SELF) port = PORT_RIGHT;
    else                  port = PORT_LOC;
  end
endmodule

// File: rtl/xp_seg_table.sv
module xp_seg_table #(
  parameter int K_SEG = 4,
  parameter int AW    = 3,
  localparam int IW   = (K_SEG > 1) ? $clog2(K_SEG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     key_src,
  input  logic [AW-1:0]     key_dst,
  input  logic              alloc_en,
  input  logic [3:0]        alloc_route,
  input  logic              rel_en,
  input  logic [IW-1:0]     rel_idx,
  output logic              free_found,
  output logic [IW-1:0]     free_idx,
  output logic              match_found,
  output logic [IW-1:0]     match_idx,
  output logic [K_SEG-1:0]  used,
  output logic [4*K_SEG-1:0] route
);
  logic [AW-1:0] src_r [K_SEG];
  logic [AW-1:0] dst_r [K_SEG];

  // ascending scan: the last hit is the highest index
  always_comb begin
    free_found  = 1'b0;
    free_idx    = '0;
    match_found = 1'b0;
    match_idx   = '0;
    for (int i = 0; i < K_SEG; i++) begin
      if (!used[i]) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
      if (used[i] && src_r[i] == key_src && dst_r[i] == key_dst) begin
        match_found = 1'b1;
        match_idx   = IW'(i);
      end
    end
  end

  for (genvar g = 0; g < K_SEG; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        used[g]          <= 1'b0;
        src_r[g]         <= '0;
        dst_r[g]         <= '0;
        route[4*g +: 4]  <= '0;
      end else if (alloc_en && free_idx == IW'(g)) begin
        used[g]          <= 1'b1;
        src_r[g]         <= key_src;
        dst_r[g]         <= key_dst;
        route[4*g +: 4]  <= alloc_route;
      end else if (rel_en && rel_idx == IW'(g)) begin
        used[g]          <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xp_ctrl.sv
module xp_ctrl #(
  parameter int N_PE   = 8,
  parameter int K_SEG  = 4,
  parameter int MY_IDX = 3,
  localparam int AW    = $clog2(N_PE),
  localparam int IW    = (K_SEG > 1) ? $clog2(K_SEG) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [2:0]           cmd_op,
  input  logic [AW-1:0]        cmd_src,
  input  logic [AW-1:0]        cmd_dst,
  output logic [2:0]           out_vld,
  output logic [8:0]           out_op,
  output logic [3*AW-1:0]      out_src,
  output logic [3*AW-1:0]      out_dst,
  output logic [K_SEG-1:0]     seg_used,
  output logic [4*K_SEG-1:0]   seg_route
);
  import xp_pkg::*;

  logic          busy_q;
  logic [2:0]    op_q;
  logic [AW-1:0] src_q, dst_q;
  logic [1:0]    p_src, p_dst;
  logic          free_found, match_found;
  logic [IW-1:0] free_idx, match_idx;
  logic          alloc_en, rel_en;
  logic [2:0]    nxt_vld;
  logic [2:0]    nxt_op [N_PORTS];
  logic [2:0]    op_r   [N_PORTS];
  logic [AW-1:0] osrc_q, odst_q;

  assign cmd_ready = !busy_q;

  // stage 1: latch the queue head
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      src_q  <= '0;
      dst_q  <= '0;
    end else begin
      busy_q <= cmd_valid && !busy_q;
      if (cmd_valid && !busy_q) begin
        op_q  <= cmd_op;
        src_q <= cmd_src;
        dst_q <= cmd_dst;
      end
    end
  end

  xp_route #(.AW(AW), .MY_IDX(MY_IDX)) u_rt_src (.addr(src_q), .port(p_src));
  xp_route #(.AW(AW), .MY_IDX(MY_IDX)) u_rt_dst (.addr(dst_q), .port(p_dst));

  xp_seg_table #(.K_SEG(K_SEG), .AW(AW)) u_tbl (
    .clk(clk), .rst(rst),
    .key_src(src_q), .key_dst(dst_q),
    .alloc_en(alloc_en), .alloc_route({p_src, p_dst}),
    .rel_en(rel_en), .rel_idx(match_idx),
    .free_found(free_found), .free_idx(free_idx),
    .match_found(match_found), .match_idx(match_idx),
    .used(seg_used), .route(seg_route)
  );

  // stage 2: decide, update the table, build the outgoing commands
  always_comb begin
    alloc_en = busy_q && op_q == OP_ACCEPT && !match_found && free_found;
    rel_en   = busy_q && op_q == OP_TEAR && match_found;
    for (int i = 0; i < N_PORTS; i++) begin
      nxt_vld[i] = 1'b0;
      nxt_op[i]  = '0;
      if (busy_q) begin
        case (op_q)
          OP_REQ, OP_TEAR: if (p_dst == 2'(i)) begin
            nxt_vld[i] = 1'b1; nxt_op[i] = op_q;
          end
          OP_REJECT, OP_TEARDN: if (p_src == 2'(i)) begin
            nxt_vld[i] = 1'b1; nxt_op[i] = op_q;
          end
          OP_ACCEPT: begin
            if (match_found || free_found) begin
              if (p_src == 2'(i)) begin
                nxt_vld[i] = 1'b1; nxt_op[i] = OP_ACCEPT;
              end
            end else begin
              if (p_dst == 2'(i)) begin
                nxt_vld[i] = 1'b1; nxt_op[i] = OP_TEAR;
              end
              if (p_src == 2'(i)) begin
                nxt_vld[i] = 1'b1; nxt_op[i] = OP_REJECT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= '0;
      osrc_q  <= '0;
      odst_q  <= '0;
      for (int i = 0; i < N_PORTS; i++) op_r[i] <= '0;
    end else begin
      out_vld <= nxt_vld;
      osrc_q  <= src_q;
      odst_q  <= dst_q;
      for (int i = 0; i < N_PORTS; i++) op_r[i] <= nxt_op[i];
    end
  end

  for (genvar g = 0; g < N_PORTS; g++) begin : g_out
    assign out_op[3*g +: 3]    = op_r[g];
    assign out_src[AW*g +: AW] = osrc_q;
    assign out_dst[AW*g +: AW] = odst_q;
  end
endmodule

// File: rtl/xp_ctrl_chk.sv
module xp_ctrl_chk #(
  parameter int N_PE   = 8,
  parameter int K_SEG  = 4,
  parameter int MY_IDX = 3,
  localparam int AW    = $clog2(N_PE)
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [2:0]         out_vld,
  input logic [8:0]         out_op,
  input logic [K_SEG-1:0]   seg_used
);
  import xp_pkg::*;
  logic any_acc, any_tear, any_rej;

  always_comb begin
    any_acc = 1'b0; any_tear = 1'b0; any_rej = 1'b0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (out_vld[i] && out_op[3*i +: 3] == OP_ACCEPT) any_acc  = 1'b1;
      if (out_vld[i] && out_op[3*i +: 3] == OP_TEAR)   any_tear = 1'b1;
      if (out_vld[i] && out_op[3*i +: 3] == OP_REJECT) any_rej  = 1'b1;
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);                        // R8
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (|out_vld) |-> $past(cmd_valid && cmd_ready, 2));                // R8
  AST_AT_MOST_TWO: assert property (@(posedge clk) disable iff (rst)
    $countones(out_vld) <= 2);                                       // R8
  AST_CLAIM_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (|(seg_used & ~$past(seg_used))) |-> any_acc);                   // R3
  AST_SINGLE_CLAIM: assert property (@(posedge clk) disable iff (rst)
    $countones(seg_used & ~$past(seg_used)) <= 1);                   // R4
  AST_RELEASE_ON_TEAR: assert property (@(posedge clk) disable iff (rst)
    (|($past(seg_used) & ~seg_used)) |-> any_tear);                  // R7
  AST_FAIL_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    (any_tear && any_rej) |-> (&seg_used));                          // R5
endmodule

bind xp_ctrl xp_ctrl_chk #(.N_PE(N_PE), .K_SEG(K_SEG), .MY_IDX(MY_IDX)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .out_vld(out_vld), .out_op(out_op), .seg_used(seg_used)
);

// File: tb/xp_ctrl_tb_top.sv
module xp_ctrl_tb_top;
  localparam int N_PE = 8, K_SEG = 4, MY_IDX = 3, AW = 3;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_src = '0, cmd_dst = '0;
  logic [2:0] out_vld;
  logic [8:0] out_op;
  logic [3*AW-1:0] out_src, out_dst;
  logic [K_SEG-1:0] seg_used;
  logic [4*K_SEG-1:0] seg_route;

  int n_chk = 0, n_bad = 0;
  bit m_vld [K_SEG];
  int m_src [K_SEG], m_dst [K_SEG], m_rt [K_SEG];

  always #(CLK_PERIOD/2) clk = ~clk;

  xp_ctrl #(.N_PE(N_PE), .K_SEG(K_SEG), .MY_IDX(MY_IDX)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
    .out_vld(out_vld), .out_op(out_op), .out_src(out_src), .out_dst(out_dst),
    .seg_used(seg_used), .seg_route(seg_route));

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int port_of(input int a);
    if (a < MY_IDX) return 1;
    if (a > MY_IDX) return 2;
    return 0;
  endfunction

  task automatic run_cmd(input int op, input int s, input int d, input string rq);
    int e_vld [3];
    int e_op [3];
    int mi, fi, ps, pd, eu;
    for (int i = 0; i < 3; i++) begin e_vld[i] = 0; e_op[i] = 0; end
    mi = -1; fi = -1;
    for (int i = 0; i < K_SEG; i++) begin
      if (!m_vld[i]) fi = i;
      if (m_vld[i] && m_src[i] == s && m_dst[i] == d) mi = i;
    end
    ps = port_of(s); pd = port_of(d);
    case (op)
      1: begin e_vld[pd] = 1; e_op[pd] = 1; end
      2: if (mi >= 0) begin e_vld[ps] = 1; e_op[ps] = 2; end
         else if (fi >= 0) begin
           e_vld[ps] = 1; e_op[ps] = 2;
           m_vld[fi] = 1; m_src[fi] = s; m_dst[fi] = d; m_rt[fi] = ps * 4 + pd;
         end else begin
           e_vld[pd] = 1; e_op[pd] = 4; e_vld[ps] = 1; e_op[ps] = 3;
         end
      3, 5: begin e_vld[ps] = 1; e_op[ps] = op; end
      4: begin
           if (mi >= 0) m_vld[mi] = 0;
           e_vld[pd] = 1; e_op[pd] = 4;
         end
      default: ;
    endcase
    chk(cmd_ready == 1'b1, "R8", "ready before issue", int'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_src = AW'(s); cmd_dst = AW'(d);
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R8", "ready after accept", int'(cmd_ready), 0);
    chk(out_vld == 3'b000, "R8", "early or stretched output", int'(out_vld), 0);
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk(int'(out_vld[i]) == e_vld[i], rq, $sformatf("valid port %0d", i),
          int'(out_vld[i]), e_vld[i]);
      if (e_vld[i] != 0 && out_vld[i]) begin
        chk(int'(out_op[3*i +: 3]) == e_op[i], rq, $sformatf("opcode port %0d", i),
            int'(out_op[3*i +: 3]), e_op[i]);
        chk(int'(out_src[AW*i +: AW]) == s && int'(out_dst[AW*i +: AW]) == d, rq,
            "pair on output", int'(out_src[AW*i +: AW]) * 8 + int'(out_dst[AW*i +: AW]),
            s * 8 + d);
      end
    end
    eu = 0;
    for (int i = 0; i < K_SEG; i++) if (m_vld[i]) eu |= (1 << i);
    chk(int'(seg_used) == eu, rq, "segment occupancy", int'(seg_used), eu);
    for (int i = 0; i < K_SEG; i++)
      if (m_vld[i])
        chk(int'(seg_route[4*i +: 4]) == m_rt[i], "R3", $sformatf("route seg %0d", i),
            int'(seg_route[4*i +: 4]), m_rt[i]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog run hung actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int s, d, op;
    void'($urandom(32'h1f2e3d4c));
    for (int i = 0; i < K_SEG; i++) begin
      m_vld[i] = 0; m_src[i] = 0; m_dst[i] = 0; m_rt[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R9 reset state
    chk(seg_used == '0, "R9", "occupancy after reset", int'(seg_used), 0);
    chk(out_vld == '0, "R9", "outputs after reset", int'(out_vld), 0);
    chk(cmd_ready == 1'b1, "R9", "ready after reset", int'(cmd_ready), 1);

    run_cmd(1, 1, 6, "R2");   // request routes right, no claim
    run_cmd(1, 6, 1, "R1");   // routes left
    run_cmd(1, 5, 3, "R1");   // local destination
    run_cmd(2, 1, 6, "R3");   // takes segment 3
    run_cmd(2, 6, 1, "R11");  // swapped pair gets segment 2
    run_cmd(2, 1, 6, "R4");   // same pair, no new segment
    run_cmd(2, 0, 3, "R3");   // segment 1
    run_cmd(2, 3, 7, "R3");   // segment 0, accept to local
    run_cmd(2, 2, 5, "R5");   // full: teardown right, reject left
    run_cmd(3, 2, 5, "R6");
    run_cmd(5, 6, 1, "R6");
    run_cmd(0, 1, 6, "R10");
    run_cmd(6, 6, 1, "R10");
    run_cmd(7, 2, 5, "R10");
    run_cmd(4, 6, 1, "R7");   // frees segment 2
    run_cmd(4, 6, 1, "R7");   // no match, only forwarded
    run_cmd(2, 2, 5, "R3");   // highest free is segment 2 again

    for (int n = 0; n < 400; n++) begin
      op = int'($urandom_range(0, 7));
      s = int'($urandom_range(0, N_PE - 1));
      d = int'($urandom_range(0, N_PE - 1));
      while (port_of(s) == port_of(d)) d = int'($urandom_range(0, N_PE - 1));
      run_cmd(op, s, d, "R1");
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule